// File: doc/BRIEF.md
# High-Bandwidth Isochronous OUT Receive Bank Manager

This block holds the receive buffers of a high-speed isochronous OUT endpoint that may carry one, two or three data packets in each 125 µs microframe. A protocol engine hands it each payload as a start strobe with a data PID code, a run of byte writes and an end strobe. The block checks that the PIDs of a microframe come in the order the configured transaction count calls for. It steers each accepted payload into the next free bank, rotating through the configured number of banks.

Each bank has its own ready flag. The hardware sets it once a payload is complete, and only a release from the reader clears it. The endpoint ready output and the interrupt are the OR of those flags. A processor or DMA engine reads the oldest full bank one byte at a time through a read port that shows the bank's byte count. It then frees the bank with a release pulse, while the engine may already be filling another bank with the next packet of the same microframe. With one bank and one transaction per microframe the block works as an ordinary single-buffered endpoint.

Top module: `hbiso_out_banks`

## Requirements
- R1: After reset no bank is full, `rd_ready`, `irq`, `seq_err` and `ovf_err` are 0, and the write and read bank pointers are at bank 0.
- R2: PID codes are 0 = DATA0, 1 = DATA1, 2 = DATA2, 3 = MDATA. With `cfg_ntrans` = 1 the only packet of a microframe must be DATA0. With 2 the order is MDATA, DATA1. With 3 the order is MDATA, MDATA, DATA2. A packet in the expected position is accepted.
- R3: A packet whose PID is not the one expected for its position, or one beyond `cfg_ntrans` in a microframe, sets `seq_err`. Its payload is discarded, and `seq_err` stays set until reset.
- R4: Accepted payloads are written to banks 0, 1, ... `cfg_nbanks`-1 in round-robin order, and the order continues across microframes.
- R5: A bank's flag in `bank_full` goes to 1 on the clock edge after the cycle in which `wr_end` closes its payload. `rd_ready` and `irq` are 1 exactly when any bank is full. A full bank stays full until it is released.
- R6: A packet aimed at a bank that is still full is dropped and sets the sticky `ovf_err`. The write pointer does not advance, so the next packet goes to that same bank.
- R7: While `rd_ready` is 1, `rd_bank` names the oldest full bank and `rd_count` gives its payload byte count. `rd_data` shows the byte at the read offset, which starts at 0 and advances by one on each clock with `rd_strobe` high.
- R8: `rd_release` while `rd_ready` is 1 clears the oldest bank's flag, moves the read port to the next bank and resets the read offset. `rd_release` while no bank is full changes nothing.
- R9: A `sof` pulse resets the expected position to the first packet of the microframe. A `wr_start` in the same cycle as `sof` counts as the first packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ntrans | input | 2 | Transactions per microframe, 1 to 3 |
| cfg_nbanks | input | 2 | Banks in use, 1 to NBANK |
| sof | input | 1 | Start-of-microframe pulse |
| wr_start | input | 1 | Start of a packet, PID valid |
| wr_pid | input | 2 | Data PID code of the starting packet |
| wr_valid | input | 1 | Payload byte valid |
| wr_data | input | 8 | Payload byte |
| wr_end | input | 1 | Payload complete |
| rd_strobe | input | 1 | Advance the read offset |
| rd_release | input | 1 | Free the oldest full bank |
| rd_ready | output | 1 | Any bank full |
| irq | output | 1 | Interrupt, same as rd_ready |
| rd_bank | output | 2 | Index of the oldest full bank |
| rd_count | output | 11 | Byte count of that bank |
| rd_data | output | 8 | Byte at the read offset |
| bank_full | output | 3 | Per-bank ready flags |
| seq_err | output | 1 | Sticky PID sequence error |
| ovf_err | output | 1 | Sticky bank overflow |

## Verification
The properties assume that `wr_start`, the byte writes and `wr_end` come in well-formed packets that never overlap. They also assume that the configuration changes only while no packet is in flight and the write pointer sits at bank 0, so that both pointers stay below `cfg_nbanks`. The driver task produces each packet as one whole start, bytes, end sequence, and the test changes `cfg_nbanks` only at points where the number of accepted packets leaves both pointers at bank 0. Sequence-error and overflow cases are set up by choosing the PIDs and by pausing the reader, never by breaking the framing.

// File: rtl/hbiso_out_banks.sv
module hbiso_out_banks #(
  parameter int NBANK      = 3,
  parameter int BANK_BYTES = 1024,
  localparam int BW = $clog2(NBANK),
  localparam int AW = $clog2(BANK_BYTES),
  localparam int CW = $clog2(BANK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_ntrans,
  input  logic [1:0]       cfg_nbanks,
  input  logic             sof,
  input  logic             wr_start,
  input  logic [1:0]       wr_pid,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             wr_end,
  input  logic             rd_strobe,
  input  logic             rd_release,
  output logic             rd_ready,
  output logic             irq,
  output logic [BW-1:0]    rd_bank,
  output logic [CW-1:0]    rd_count,
  output logic [7:0]       rd_data,
  output logic [NBANK-1:0] bank_full,
  output logic             seq_err,
  output logic             ovf_err
);
  localparam logic [1:0] PID_DATA0 = 2'd0, PID_DATA1 = 2'd1, PID_DATA2 = 2'd2, PID_MDATA = 2'd3;

  logic [7:0]    mem [NBANK][BANK_BYTES];
  logic [CW-1:0] cnt [NBANK];
  logic [1:0]    idx;
  logic [BW-1:0] wptr, rptr;
  logic [CW-1:0] wcnt;
  logic [AW-1:0] raddr;
  logic          rx_on;

  logic [1:0] cur_idx, exp_pid;
  logic       pid_ok, do_rel, do_done;
  logic [NBANK-1:0] set_v, clr_v;

  assign cur_idx = sof ? 2'd0 : idx;
  assign exp_pid = (cur_idx != cfg_ntrans - 2'd1) ? PID_MDATA :
                   (cfg_ntrans == 2'd1) ? PID_DATA0 :
                   (cfg_ntrans == 2'd2) ? PID_DATA1 : PID_DATA2;
  assign pid_ok  = (cur_idx < cfg_ntrans) && (wr_pid == exp_pid);
  assign do_done = wr_end && rx_on;
  assign do_rel  = rd_release && bank_full[rptr];

  function automatic logic [BW-1:0] nxt(input logic [BW-1:0] p, input logic [1:0] n);
    return ({{(8-BW){1'b0}}, p} >= 8'(n) - 8'd1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (do_done) set_v[wptr] = 1'b1;
    if (do_rel)  clr_v[rptr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; wptr <= '0; rptr <= '0; wcnt <= '0; raddr <= '0;
      rx_on <= 1'b0; seq_err <= 1'b0; ovf_err <= 1'b0; bank_full <= '0;
    end else begin
      bank_full <= (bank_full & ~clr_v) | set_v;
      if (wr_start) begin
        idx  <= (cur_idx == 2'd3) ? 2'd3 : cur_idx + 2'd1;
        wcnt <= '0;
        if (!pid_ok) begin
          seq_err <= 1'b1;
          rx_on   <= 1'b0;
        end else if (bank_full[wptr]) begin
          ovf_err <= 1'b1;
          rx_on   <= 1'b0;
        end else begin
          rx_on <= 1'b1;
        end
      end else if (sof) begin
        idx <= '0;
      end
      if (wr_valid && rx_on && wcnt < CW'(BANK_BYTES)) wcnt <= wcnt + 1'b1;
      if (do_done) begin
        rx_on <= 1'b0;
        wptr  <= nxt(wptr, cfg_nbanks);
      end
      if (do_rel) begin
        rptr  <= nxt(rptr, cfg_nbanks);
        raddr <= '0;
      end else if (rd_strobe && bank_full[rptr]) begin
        raddr <= raddr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid && rx_on && wcnt < CW'(BANK_BYTES)) mem[wptr][wcnt[AW-1:0]] <= wr_data;
    if (do_done) cnt[wptr] <= wcnt;
  end

  assign rd_ready = |bank_full;
  assign irq      = rd_ready;
  assign rd_bank  = rptr;
  assign rd_count = cnt[rptr];
  assign rd_data  = mem[rptr][raddr];
endmodule

module hbiso_out_banks_chk #(
  parameter int NBANK = 3,
  localparam int BW = $clog2(NBANK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_end,
  input logic             rd_release,
  input logic             rd_ready,
  input logic             irq,
  input logic [BW-1:0]    rd_bank,
  input logic [NBANK-1:0] bank_full,
  input logic             seq_err,
  input logic             ovf_err
);
  a_r3_seq_sticky: assert property (@(posedge clk) disable iff (!rst_n) seq_err |=> seq_err);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n) ovf_err |=> ovf_err);
  a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready && !rd_release |=> rd_ready);
  a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready && rd_release |=> !bank_full[$past(rd_bank)]);
  a_r8_empty_release_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready && !wr_end |=> !rd_ready && $stable(rd_bank));
  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n) irq == (bank_full != '0));
endmodule

bind hbiso_out_banks hbiso_out_banks_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .rd_release(rd_release),
  .rd_ready(rd_ready), .irq(irq), .rd_bank(rd_bank), .bank_full(bank_full),
  .seq_err(seq_err), .ovf_err(ovf_err)
);

// File: tb/test_hbiso_out_banks.sv
module test_hbiso_out_banks;
  localparam int CLK_P = 10;
  localparam logic [1:0] DATA0 = 2'd0, DATA1 = 2'd1, DATA2 = 2'd2, MDATA = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_ntrans = 2'd1, cfg_nbanks = 2'd1;
  logic sof = 1'b0, wr_start = 1'b0, wr_valid = 1'b0, wr_end = 1'b0;
  logic [1:0] wr_pid = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic rd_strobe = 1'b0, rd_release = 1'b0;
  logic rd_ready, irq, seq_err, ovf_err;
  logic [1:0] rd_bank;
  logic [10:0] rd_count;
  logic [7:0] rd_data;
  logic [2:0] bank_full;

  hbiso_out_banks i_hbiso_out_banks (
    .clk(clk), .rst_n(rst_n), .cfg_ntrans(cfg_ntrans), .cfg_nbanks(cfg_nbanks),
    .sof(sof), .wr_start(wr_start), .wr_pid(wr_pid), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_end(wr_end), .rd_strobe(rd_strobe), .rd_release(rd_release),
    .rd_ready(rd_ready), .irq(irq), .rd_bank(rd_bank), .rd_count(rd_count),
    .rd_data(rd_data), .bank_full(bank_full), .seq_err(seq_err), .ovf_err(ovf_err));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  int q_bank[$], q_len[$], q_seed[$];
  int wptr_m = 0;
  bit mon_en = 1'b0, mon_busy = 1'b0;

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed * 13 + i * 7 + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_sof();
    @(negedge clk) sof = 1'b1;
    @(negedge clk) sof = 1'b0;
  endtask

  task automatic send(logic [1:0] pid, int len, int seed, bit ok);
    @(negedge clk);
    wr_start = 1'b1; wr_pid = pid;
    @(negedge clk);
    wr_start = 1'b0;
    for (int i = 0; i < len; i++) begin
      wr_valid = 1'b1; wr_data = pat(seed, i);
      @(negedge clk);
    end
    wr_valid = 1'b0; wr_end = 1'b1;
    if (ok) begin
      q_bank.push_back(wptr_m); q_len.push_back(len); q_seed.push_back(seed);
      wptr_m = (wptr_m + 1) % int'(cfg_nbanks);
    end
    @(negedge clk);
    wr_end = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((q_bank.size() != 0 || mon_busy || rd_ready) && n < 20000) begin
      @(negedge clk); n++;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (mon_en && rd_ready) begin
        int b, l, s, errs;
        mon_busy = 1'b1;
        if (q_bank.size() == 0) begin
          check(1'b0, "R3 unexpected payload", int'(rd_count), 0);
          b = -1; l = int'(rd_count); s = 0;
        end else begin
          b = q_bank.pop_front(); l = q_len.pop_front(); s = q_seed.pop_front();
        end
        check(int'(rd_bank) == b, "R4 bank order", int'(rd_bank), b);
        check(int'(rd_count) == l, "R7 byte count", int'(rd_count), l);
        errs = 0;
        for (int i = 0; i < l; i++) begin
          if (rd_data !== pat(s, i)) errs++;
          rd_strobe = 1'b1;
          @(negedge clk);
        end
        rd_strobe = 1'b0;
        check(errs == 0, "R7 payload bytes", errs, 0);
        rd_release = 1'b1;
        @(negedge clk);
        rd_release = 1'b0;
        mon_busy = 1'b0;
      end
    end
  end

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd_ready && !irq, "R1 ready after reset", int'(rd_ready), 0);
    check(bank_full == 3'b000, "R1 banks empty", int'(bank_full), 0);
    check(!seq_err && !ovf_err, "R1 error flags", int'({seq_err, ovf_err}), 0);

    // R2 single transaction, single bank
    mon_en = 1'b1;
    pulse_sof(); send(DATA0, 5, 1, 1'b1);
    drain();

    // R2, R4 three transactions across three banks, two microframes
    cfg_ntrans = 2'd3; cfg_nbanks = 2'd3;
    for (int m = 0; m < 2; m++) begin
      pulse_sof();
      send(MDATA, 20, 10 + m, 1'b1);
      send(MDATA, 33, 20 + m, 1'b1);
      send(DATA2, 17, 30 + m, 1'b1);
    end
    drain();
    check(!seq_err && !ovf_err, "R2 legal order keeps errors clear", int'({seq_err, ovf_err}), 0);

    // R2 two transactions on two banks
    cfg_ntrans = 2'd2; cfg_nbanks = 2'd2;
    pulse_sof(); send(MDATA, 12, 40, 1'b1); send(DATA1, 9, 41, 1'b1);
    drain();
    check(!seq_err, "R2 MDATA then DATA1 accepted", int'(seq_err), 0);

    // R3 wrong order discarded
    pulse_sof(); send(DATA1, 8, 50, 1'b0);
    check(seq_err, "R3 out-of-order PID flagged", int'(seq_err), 1);
    send(MDATA, 8, 51, 1'b0);
    repeat (3) @(negedge clk);
    check(!rd_ready, "R3 discarded payload not ready", int'(rd_ready), 0);
    pulse_sof(); send(MDATA, 6, 52, 1'b1); send(DATA1, 7, 53, 1'b1);
    drain();
    check(seq_err, "R3 flag sticky", int'(seq_err), 1);

    // R3 beyond count
    cfg_ntrans = 2'd1;
    pulse_sof(); send(DATA0, 4, 60, 1'b1); send(DATA0, 4, 61, 1'b0);
    drain();

    // R9 sof restarts the expected position
    cfg_ntrans = 2'd2;
    pulse_sof(); send(MDATA, 5, 70, 1'b1);
    pulse_sof(); send(MDATA, 5, 71, 1'b1); send(DATA1, 5, 72, 1'b1);
    drain();
    check(q_bank.size() == 0, "R9 all restarted packets delivered", q_bank.size(), 0);

    // R5, R6 overflow with reader paused
    mon_en = 1'b0;
    cfg_ntrans = 2'd1;
    pulse_sof(); send(DATA0, 10, 80, 1'b1);
    check(rd_ready && irq, "R5 ready one edge after end", int'(rd_ready), 1);
    check(bank_full == 3'b001, "R5 bank 0 flag", int'(bank_full), 1);
    pulse_sof(); send(DATA0, 11, 81, 1'b1);
    check(bank_full == 3'b011, "R5 both flags", int'(bank_full), 3);
    check(!ovf_err, "R6 no overflow yet", int'(ovf_err), 0);
    pulse_sof(); send(DATA0, 12, 82, 1'b0);
    check(ovf_err, "R6 overflow flagged", int'(ovf_err), 1);
    check(bank_full == 3'b011 && rd_bank == 2'd0, "R6 banks unchanged", int'(bank_full), 3);
    mon_en = 1'b1;
    drain();
    pulse_sof(); send(DATA0, 9, 83, 1'b1);
    drain();

    // R8 release with nothing full is ignored
    mon_en = 1'b0;
    @(negedge clk) rd_release = 1'b1;
    @(negedge clk) rd_release = 1'b0;
    check(!rd_ready && rd_bank == 2'd1, "R8 empty release ignored", int'(rd_bank), 1);
    pulse_sof(); send(DATA0, 6, 90, 1'b1);
    mon_en = 1'b1;
    drain();
    check(ovf_err && seq_err, "R6 R3 sticky at end", int'({seq_err, ovf_err}), 3);
    check(q_bank.size() == 0, "R8 scoreboard empty", q_bank.size(), 0);
    finish_up();
  end
endmodule